// File: doc/BRIEF.md
# Prioritized Address Window Decoder

This block takes the address of an external bus access and decides which of five timing configuration sets governs it. There are four programmable windows. Each has an enable bit, a base address and a size written as a power-of-two exponent. Any address that no enabled window claims falls to configuration 0, the default set. Alongside the winning index the block drives five active-low chip selects: one per window and one for the default region. Exactly one of them is low for every access, so memories and peripherals need no external decode logic.

Windows may overlap, and the overlap resolves through a hierarchy built from pairs. Window 4 beats window 3, and window 2 beats window 1. Any hit in the upper pair (3/4) beats any hit in the lower pair (1/2). A bus-cycle sequencer reads the index to load the matching wait-state and strobe parameters.

The decode is combinational by default. A parameter adds one output register stage when the address path must be timed against a clock edge.

Top module: `awd_decoder`

## Requirements
- R1: Window n (n = 1..4, using ports `win_en[n-1]`, `win_base[n-1]` and `win_size[n-1]`) hits when it is enabled and `addr` equals `win_base` in every bit at position k and above, where k is `win_size`. The base bits below k are ignored. When k is at least ADDR_W, the window covers the whole address space.
- R2: A window whose enable bit is 0 never hits, whatever its base and size.
- R3: When windows 4 and 3 both hit, `cfg_sel` is 4.
- R4: When windows 2 and 1 both hit and neither 3 nor 4 hits, `cfg_sel` is 2.
- R5: When any window of the upper pair (3, 4) hits, `cfg_sel` is 3 or 4, whatever the lower pair (1, 2) does.
- R6: When no enabled window hits, `cfg_sel` is 0 and `cs_n[0]` is low.
- R7: `cs_n` is active low and one-hot: bit i is low exactly when `cfg_sel` equals i, and all other bits are high.
- R8: With REG_OUT = 0, `cfg_sel` and `cs_n` follow the inputs in the same cycle, with no clock edge between them.
- R9: With REG_OUT = 1, `cfg_sel` and `cs_n` show the decode of the inputs sampled at the previous rising clock edge. While `rst_n` is low they hold `cfg_sel` = 0 and `cs_n` all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address being decoded |
| win_en | input | 4 | Enable bits; bit n-1 enables window n |
| win_base | input | 4 x ADDR_W | Base address of each window |
| win_size | input | 4 x SZ_W | log2 of each window's size in bytes |
| cfg_sel | output | 3 | Winning configuration set, 0 (default) to 4 |
| cs_n | output | 5 | Active-low one-hot chip selects; bit 0 is the default region |

## Verification
Directed cases put the address inside several windows at once, in the combinations 3+4, 1+2, 1+3 and all four. Each combination shows whether the in-pair rule or the cross-pair rule picked the winner. Further directed cases cover a disabled window whose base matches exactly and a size-0 window tried with and without a one-bit difference. They also cover a full-space window, and a mid-size window that is tested with junk in the ignored low base bits and then with a difference just above the boundary. A long random run places bases near the address half of the time, so that single hits, multiple hits and the default region all occur often, and it compares the combinational and the registered instance against the same model.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int unsigned AWD_NWIN  = 4;
   localparam int unsigned AWD_NCS   = AWD_NWIN + 1;
   localparam int unsigned AWD_SEL_W = $clog2(AWD_NCS);
   typedef logic [AWD_SEL_W-1:0] awd_sel_t;
endpackage

// File: rtl/awd_window_match.sv
module awd_window_match #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SZ_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic              en,
   output logic              hit
);
   logic [ADDR_W-1:0] keep_mask;

   always_comb begin
      for (int b = 0; b < ADDR_W; b++) begin
         keep_mask[b] = (b >= int'(size_log2));
      end
      hit = en && (((addr ^ base) & keep_mask) == '0);
   end
endmodule

// File: rtl/awd_pair_pick.sv
module awd_pair_pick
   import awd_pkg::*;
#(
   parameter int unsigned LO_IDX = 1,
   parameter int unsigned HI_IDX = 2
) (
   input  logic     hit_lo,
   input  logic     hit_hi,
   output logic     any_hit,
   output awd_sel_t sel
);
   always_comb begin
      any_hit = hit_lo | hit_hi;
      if (hit_hi)      sel = awd_sel_t'(HI_IDX);
      else if (hit_lo) sel = awd_sel_t'(LO_IDX);
      else             sel = '0;
   end
endmodule

// File: rtl/awd_cs_onehot.sv
module awd_cs_onehot
   import awd_pkg::*;
(
   input  awd_sel_t             sel,
   input  logic                 active,
   output logic [AWD_NCS-1:0]   cs_n
);
   for (genvar i = 0; i < AWD_NCS; i++) begin : g_cs
      assign cs_n[i] = !(active && (sel == awd_sel_t'(i)));
   end
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
   import awd_pkg::*;
#(
   parameter int unsigned ADDR_W  = 24,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned SZ_W   = $clog2(ADDR_W + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [AWD_NWIN-1:0]              win_en,
   input  logic [AWD_NWIN-1:0][ADDR_W-1:0]  win_base,
   input  logic [AWD_NWIN-1:0][SZ_W-1:0]    win_size,
   output logic [AWD_SEL_W-1:0]             cfg_sel,
   output logic [AWD_NCS-1:0]               cs_n
);
   localparam int unsigned NPAIR = AWD_NWIN / 2;

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
      $error("awd_decoder: ADDR_W must lie in 2..64");
   end
   if (AWD_NWIN != 4) begin : g_bad_nwin
      $error("awd_decoder: pairwise hierarchy needs exactly four windows");
   end

   logic [AWD_NWIN-1:0] hit;
   logic [NPAIR-1:0]    pair_any;
   awd_sel_t            pair_sel [NPAIR];
   awd_sel_t            comb_sel;
   awd_sel_t            out_sel;
   logic                out_act;

   // one comparator per window
   for (genvar w = 0; w < AWD_NWIN; w++) begin : g_win
      awd_window_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
         .addr      (addr),
         .base      (win_base[w]),
         .size_log2 (win_size[w]),
         .en        (win_en[w]),
         .hit       (hit[w])
      );
   end

   // in-pair resolution: higher-numbered window of each pair wins
   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      awd_pair_pick #(.LO_IDX(2*p + 1), .HI_IDX(2*p + 2)) u_pick (
         .hit_lo  (hit[2*p]),
         .hit_hi  (hit[2*p + 1]),
         .any_hit (pair_any[p]),
         .sel     (pair_sel[p])
      );
   end

   // cross-pair resolution: upper pair over lower pair, else default set
   always_comb begin
      if (pair_any[1])      comb_sel = pair_sel[1];
      else if (pair_any[0]) comb_sel = pair_sel[0];
      else                  comb_sel = '0;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_sel <= '0;
            out_act <= 1'b0;
         end else begin
            out_sel <= comb_sel;
            out_act <= 1'b1;
         end
      end

      AST_REG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (cfg_sel == $past(comb_sel)) && !cs_n[$past(comb_sel)]) // R9
         else $error("registered output does not match previous decode");
   end else begin : g_comb
      assign out_sel = comb_sel;
      assign out_act = 1'b1;
   end

   awd_cs_onehot u_cs (
      .sel    (out_sel),
      .active (out_act),
      .cs_n   (cs_n)
   );

   assign cfg_sel = out_sel;

   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel <= awd_sel_t'(AWD_NWIN)) // R7
      else $error("cfg_sel out of range");
   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n)) // R7
      else $error("more than one chip select low");
   AST_CS_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n != '1) |-> !cs_n[cfg_sel]) // R7
      else $error("chip select disagrees with cfg_sel");
   AST_W4_OVER_W3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[3] |-> comb_sel == awd_sel_t'(4)) // R3
      else $error("window 4 lost");
   AST_W2_OVER_W1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[1] && !hit[2] && !hit[3]) |-> comb_sel == awd_sel_t'(2)) // R4
      else $error("window 2 lost");
   AST_UPPER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[2] || hit[3]) |-> comb_sel >= awd_sel_t'(3)) // R5
      else $error("lower pair beat upper pair");
   AST_DEFAULT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> comb_sel == '0) // R6
      else $error("unmatched address not routed to default");
   for (genvar w = 0; w < AWD_NWIN; w++) begin : g_dis_chk
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !win_en[w] |-> comb_sel != awd_sel_t'(w + 1)) // R2
         else $error("disabled window selected");
   end
endmodule

// File: tb/awd_decoder_test.sv
module awd_decoder_test;
   localparam int unsigned ADDR_W = 24;
   localparam int unsigned SZ_W   = $clog2(ADDR_W + 1);

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic [ADDR_W-1:0]         addr = '0;
   logic [3:0]                win_en = '0;
   logic [3:0][ADDR_W-1:0]    win_base = '0;
   logic [3:0][SZ_W-1:0]      win_size = '0;
   logic [2:0]                sel_c, sel_r;
   logic [4:0]                cs_c, cs_r;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   awd_decoder #(.ADDR_W(ADDR_W), .REG_OUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .win_en(win_en),
      .win_base(win_base), .win_size(win_size), .cfg_sel(sel_c), .cs_n(cs_c));

   awd_decoder #(.ADDR_W(ADDR_W), .REG_OUT(1'b1)) uut_reg (
      .clk(clk), .rst_n(rst_n), .addr(addr), .win_en(win_en),
      .win_base(win_base), .win_size(win_size), .cfg_sel(sel_r), .cs_n(cs_r));

   function automatic bit model_hit(int n);
      int k = int'(win_size[n]);
      if (!win_en[n]) return 1'b0;
      if (k >= int'(ADDR_W)) return 1'b1;
      return (addr >> k) == (win_base[n] >> k);
   endfunction

   function automatic logic [2:0] model_sel();
      for (int n = 3; n >= 0; n--) if (model_hit(n)) return 3'(n + 1);
      return 3'd0;
   endfunction

   function automatic logic [4:0] model_cs(logic [2:0] s);
      return ~(5'b00001 << s);
   endfunction

   task automatic check(string req, logic [2:0] as, logic [4:0] ac,
                        logic [2:0] es, logic [4:0] ec);
      checks++;
      if (as !== es || ac !== ec) begin
         errors++;
         $display("FAIL %s: cfg_sel=%0d cs_n=%b expected cfg_sel=%0d cs_n=%b",
                  req, as, ac, es, ec);
      end
   endtask

   // inputs are set at a falling edge; comb checked 1 ns later, reg after next rising edge
   task automatic run(string req);
      logic [2:0] es;
      #1;
      es = model_sel();
      check({req, "/R8 comb"}, sel_c, cs_c, es, model_cs(es));
      @(posedge clk);
      #1;
      check({req, "/R9 reg"}, sel_r, cs_r, es, model_cs(es));
      @(negedge clk);
   endtask

   task automatic set_win(int n, bit en, logic [ADDR_W-1:0] b, int k);
      win_en[n]   = en;
      win_base[n] = b;
      win_size[n] = SZ_W'(k);
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      addr = 24'h123456;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset", sel_r, cs_r, 3'd0, 5'b11111);
      @(negedge clk);
      rst_n = 1'b1;

      // R6 / R2: all disabled although bases equal address
      for (int n = 0; n < 4; n++) set_win(n, 1'b0, addr, 0);
      run("R6 all disabled");
      // R3 / R5: all enabled and covering the address
      for (int n = 0; n < 4; n++) set_win(n, 1'b1, addr, 4);
      run("R5 all hit");
      // R3: windows 3 and 4 only
      set_win(0, 1'b0, addr, 4); set_win(1, 1'b0, addr, 4);
      run("R3 w3+w4");
      // R4: windows 1 and 2 only
      set_win(0, 1'b1, addr, 8); set_win(1, 1'b1, addr, 2);
      set_win(2, 1'b0, addr, 0); set_win(3, 1'b0, addr, 0);
      run("R4 w1+w2");
      // R5: windows 1 and 3
      set_win(1, 1'b0, addr, 0); set_win(2, 1'b1, addr, 12);
      run("R5 w1+w3");
      // R2: only window 4 matches but is disabled
      for (int n = 0; n < 4; n++) set_win(n, 1'b0, addr, 0);
      set_win(0, 1'b1, addr ^ 24'h800000, 4);
      run("R2 disabled w4");
      // R1: size 0 exact and off-by-one-bit
      set_win(1, 1'b1, addr, 0);
      run("R1 size0 exact");
      set_win(1, 1'b1, addr ^ 24'h000001, 0);
      run("R1 size0 miss");
      // R1: full address space
      set_win(2, 1'b1, 24'hABCDEF, ADDR_W);
      run("R1 full space");
      set_win(2, 1'b0, 24'h0, 0);
      // R1: size 2^8, junk in low base bits, then difference at bit 8
      set_win(3, 1'b1, addr ^ 24'h0000FF, 8);
      run("R1 low bits ignored");
      set_win(3, 1'b1, addr ^ 24'h000100, 8);
      run("R1 boundary miss");

      // random mix
      for (int it = 0; it < 3000; it++) begin
         addr = ADDR_W'($urandom);
         for (int n = 0; n < 4; n++) begin
            logic [ADDR_W-1:0] junk;
            junk = ADDR_W'($urandom) & ((ADDR_W'(1) << ($urandom % ADDR_W)) - 1'b1);
            set_win(n, ($urandom % 4) != 0,
                    ($urandom % 2) ? (addr ^ junk) : ADDR_W'($urandom),
                    int'($urandom % (ADDR_W + 3)));
         end
         run("R7 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule